// File: doc/BRIEF.md
# Byte-wide host command mailbox

This block sits between a host processor's byte-wide I/O bus and an internal command engine. It carries whole command packets in both directions. Only two port offsets are decoded. Offset 0 is the data port. Offset 1 returns a status byte when read and takes a command code when written. A one-byte input holding register and a one-byte output holding register each carry a full flag, and a small mode sequencer wraps every exchange in a fixed protocol.

A send starts with a cancel code and then a normal-mode code. The host then writes its payload one byte at a time, each time waiting for the input-full flag to clear, and closes the packet with an end-of-command code. The engine receives these bytes on a valid/ready stream. The end code itself reaches the engine as a final beat marked last, carrying 0x03. Once the engine takes that beat, the mailbox places a header byte 0x01 in the output register with the frame flag set. The engine then streams its response bytes back on a second valid/ready stream, marking the final one last. After the host has read that final byte, the mailbox places a trailer byte 0x03 with the frame flag set again. A response carries at least six payload bytes, and bytes 2 to 5 hold the total length as a big-endian 32-bit value. The engine is responsible for that length. The mailbox passes response bytes through without looking at them.

Back-pressure works as follows. On the host-to-engine stream, `rx_valid` stays high with `rx_data` and `rx_last` held until the engine raises `rx_ready`. The host is held off through the input-full status flag. On the engine-to-host stream, `tx_ready` is high only while the output register is empty during the response phase. The engine keeps `tx_valid` and its data until a cycle in which `tx_ready` is high. A cancel code aborts any exchange and raises `eng_abort` for one cycle.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the status byte is 0x10 (ready for command only), `rx_valid` is 0, `tx_ready` is 0 and `eng_abort` is 0.
- R2: With `host_addr`=0, `host_rdata` returns the output register. With `host_addr`=1 it returns status, with these bits: bit0 output full, bit1 input full, bit2 frame flag, bit3 last-write-was-command, bit4 ready for command, bit5 ready for data, bits 7:6 zero.
- R3: After any host write, status bit3 equals the offset of that write (1 for the command port, 0 for the data port).
- R4: Writing 0x01 to offset 1 in the ready state gives, in the next cycle, bit5=1 and bit4=0. Codes other than 0x01 and 0x22 written in the ready state change nothing but bit3.
- R5: A data write while bit5=1 and input full is 0 sets input full and shows the byte on `rx_data` with `rx_last`=0 from the next cycle. The beat is held stable until it is popped by `rx_valid`&&`rx_ready`, and the pop clears input full in the next cycle. Data writes while input full is 1, or outside the ready-for-data state, are ignored.
- R6: Writing 0x03 to offset 1 while bit5=1 and input full is 0 offers a beat with data 0x03 and `rx_last`=1. When that beat is popped, the next cycle shows bit5=0, output full=1, frame flag=1 and 0x01 at offset 0.
- R7: A data-port read while output full is 1 clears output full and the frame flag in the next cycle. Reads of the status port, or data reads while output full is 0, change nothing.
- R8: `tx_ready` is 1 only in the response phase, while output full is 0 and no trailer is pending. An accepted byte appears at offset 0 in the next cycle with output full=1 and the frame flag clear.
- R9: The host read that takes the byte accepted with `tx_last`=1 loads the trailer 0x03 in the same edge, with output full=1 and the frame flag set. Reading the trailer returns the block to the ready-for-command state.
- R10: Writing 0x22 to offset 1 in any state gives, in the next cycle, status 0x18, `rx_valid`=0 and `tx_ready`=0, and raises `eng_abort` for exactly that one cycle. This holds even directly after another command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs | input | 1 | Host access strobe for this block |
| host_wr | input | 1 | Host write, qualified by host_cs |
| host_rd | input | 1 | Host read, qualified by host_cs |
| host_addr | input | 1 | Port offset: 0 data, 1 status/command |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational from offset) |
| rx_valid | output | 1 | Host-to-engine beat available |
| rx_ready | input | 1 | Engine takes the beat |
| rx_data | output | 8 | Host-to-engine byte |
| rx_last | output | 1 | Beat is the end-of-command marker |
| tx_valid | input | 1 | Engine offers a response byte |
| tx_ready | output | 1 | Mailbox accepts the response byte |
| tx_data | input | 8 | Response byte |
| tx_last | input | 1 | Final response byte |
| eng_abort | output | 1 | One-cycle abort pulse after cancel |

## Verification
Every result of a host write, host data read, engine pop or engine accept becomes visible in the cycle after the clock edge that samples it. The one exception is `host_rdata`, a combinational view of the registers and the current offset, so a read returns the value as it stands before its edge. The bench drives all inputs just after the falling edge. It updates a behavioural model on the rising edge from the same sampled inputs, and compares all outputs at the next falling edge, so every comparison lands one edge after its stimulus. Directed checks sample status and stream pins just after a task's sampling edge has passed. The trailer case is checked in the cycle straight after the read that takes the last response byte.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  parameter int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t CODE_NORMAL = byte_t'(8'h01);
  localparam byte_t CODE_END    = byte_t'(8'h03);
  localparam byte_t CODE_CANCEL = byte_t'(8'h22);
  localparam byte_t HEAD_BYTE   = byte_t'(8'h01);
  localparam byte_t TAIL_BYTE   = byte_t'(8'h03);

  localparam int SB_OUTFULL = 0;
  localparam int SB_INFULL  = 1;
  localparam int SB_FRAME   = 2;
  localparam int SB_CMDPORT = 3;
  localparam int SB_CMDRDY  = 4;
  localparam int SB_DATARDY = 5;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SEND  = 2'd1,
    PH_REPLY = 2'd2,
    PH_TAIL  = 2'd3
  } phase_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
(
  input  logic  host_cs,
  input  logic  host_wr,
  input  logic  host_rd,
  input  logic  host_addr,
  input  byte_t host_wdata,
  input  byte_t status,
  input  byte_t out_byte,
  output logic  ev_dwr,
  output logic  ev_cwr,
  output logic  ev_drd,
  output logic  ev_cancel,
  output logic  ev_normal,
  output logic  ev_end,
  output byte_t host_rdata
);
  always_comb begin
    ev_dwr    = host_cs && host_wr && !host_addr;
    ev_cwr    = host_cs && host_wr && host_addr;
    ev_drd    = host_cs && host_rd && !host_wr && !host_addr;
    ev_cancel = ev_cwr && (host_wdata == CODE_CANCEL);
    ev_normal = ev_cwr && (host_wdata == CODE_NORMAL);
    ev_end    = ev_cwr && (host_wdata == CODE_END);
    host_rdata = host_addr ? status : out_byte;
  end
endmodule

// File: rtl/mbx_inbox.sv
module mbx_inbox
  import mbx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flush,
  input  logic  ld_byte,
  input  logic  ld_end,
  input  byte_t wdata,
  input  logic  pop,
  output logic  full,
  output byte_t held,
  output logic  is_end
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      held   <= '0;
      is_end <= 1'b0;
    end else if (flush) begin
      full   <= 1'b0;
      is_end <= 1'b0;
    end else if (ld_byte || ld_end) begin
      full   <= 1'b1;
      held   <= ld_end ? TAIL_BYTE : wdata;
      is_end <= ld_end;
    end else if (pop) begin
      full   <= 1'b0;
      is_end <= 1'b0;
    end
  end

  // R5: a load never lands on an occupied register
  a_r5_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_byte || ld_end) |-> !full);

  // R5: an unpopped beat stays put
  a_r5_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !flush) |=> (full && $stable(held) && $stable(is_end)));
endmodule

// File: rtl/mbx_outbox.sv
module mbx_outbox
  import mbx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flush,
  input  logic  ld_head,
  input  logic  ld_eng,
  input  logic  ld_tail,
  input  byte_t eng_byte,
  input  logic  take,
  output logic  full,
  output logic  frame,
  output byte_t held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full  <= 1'b0;
      frame <= 1'b0;
      held  <= '0;
    end else if (flush) begin
      full  <= 1'b0;
      frame <= 1'b0;
    end else if (ld_head || ld_tail) begin
      full  <= 1'b1;
      frame <= 1'b1;
      held  <= ld_head ? HEAD_BYTE : TAIL_BYTE;
    end else if (ld_eng) begin
      full  <= 1'b1;
      frame <= 1'b0;
      held  <= eng_byte;
    end else if (take) begin
      full  <= 1'b0;
      frame <= 1'b0;
    end
  end

  // R7: the frame flag only accompanies a pending byte
  a_r7_frame_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    frame |-> full);

  // R8: the engine never writes over an unread byte
  a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    ld_eng |-> !full);
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ev_dwr,
  input  logic  ev_cwr,
  input  logic  ev_drd,
  input  logic  ev_cancel,
  input  logic  ev_normal,
  input  logic  ev_end,
  input  logic  in_full,
  input  logic  in_is_end,
  input  logic  rx_ready,
  input  logic  out_full,
  input  logic  out_frame,
  input  logic  tx_valid,
  input  logic  tx_last,
  output logic  flush,
  output logic  ld_byte,
  output logic  ld_end,
  output logic  pop,
  output logic  ld_head,
  output logic  ld_eng,
  output logic  ld_tail,
  output logic  take,
  output logic  tx_ready,
  output byte_t status,
  output logic  eng_abort
);
  phase_e phase;
  logic   tail_due;
  logic   cmd_port;

  always_comb begin
    flush    = ev_cancel;
    pop      = in_full && rx_ready;
    ld_byte  = ev_dwr && (phase == PH_SEND) && !in_full;
    ld_end   = ev_end && (phase == PH_SEND) && !in_full;
    ld_head  = pop && in_is_end && (phase == PH_SEND);
    tx_ready = (phase == PH_REPLY) && !out_full && !tail_due;
    ld_eng   = tx_valid && tx_ready;
    take     = ev_drd && out_full;
    ld_tail  = take && tail_due;
    status   = '0;
    status[SB_OUTFULL] = out_full;
    status[SB_INFULL]  = in_full;
    status[SB_FRAME]   = out_frame;
    status[SB_CMDPORT] = cmd_port;
    status[SB_CMDRDY]  = (phase == PH_IDLE);
    status[SB_DATARDY] = (phase == PH_SEND);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      tail_due  <= 1'b0;
      cmd_port  <= 1'b0;
      eng_abort <= 1'b0;
    end else begin
      eng_abort <= ev_cancel;
      if (ev_dwr || ev_cwr) cmd_port <= ev_cwr;
      if (ev_cancel) begin
        phase    <= PH_IDLE;
        tail_due <= 1'b0;
      end else begin
        unique case (phase)
          PH_IDLE:  if (ev_normal) phase <= PH_SEND;
          PH_SEND:  if (ld_head) phase <= PH_REPLY;
          PH_REPLY: begin
            if (ld_eng && tx_last) tail_due <= 1'b1;
            if (ld_tail) begin
              tail_due <= 1'b0;
              phase    <= PH_TAIL;
            end
          end
          PH_TAIL:  if (take) phase <= PH_IDLE;
          default:  phase <= PH_IDLE;
        endcase
      end
    end
  end

  // R10: cancel empties both registers and returns to command-ready
  a_r10_cancel_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cancel |=> (phase == PH_IDLE && !in_full && !out_full && eng_abort));

  // R6: popping the end marker raises a framed header
  a_r6_head_framed: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_head && !flush) |=> (out_full && out_frame));

  // R9: trailer is framed right after the last byte is taken
  a_r9_tail_framed: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_tail && !flush) |=> (out_full && out_frame && phase == PH_TAIL));

  // R8: no engine byte is accepted while a trailer waits
  a_r8_no_accept_tail: assert property (@(posedge clk) disable iff (!rst_n)
    tail_due |-> !tx_ready);
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_cs,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic       host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  output logic       rx_last,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data,
  input  logic       tx_last,
  output logic       eng_abort
);
  logic  ev_dwr, ev_cwr, ev_drd, ev_cancel, ev_normal, ev_end;
  logic  flush, ld_byte, ld_end, pop, ld_head, ld_eng, ld_tail, take;
  logic  in_full, in_is_end, out_full, out_frame;
  byte_t in_held, out_held, status;

  mbx_decode u_dec (
    .host_cs(host_cs), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .status(status), .out_byte(out_held),
    .ev_dwr(ev_dwr), .ev_cwr(ev_cwr), .ev_drd(ev_drd),
    .ev_cancel(ev_cancel), .ev_normal(ev_normal), .ev_end(ev_end),
    .host_rdata(host_rdata)
  );

  mbx_inbox u_in (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ld_byte(ld_byte), .ld_end(ld_end), .wdata(host_wdata), .pop(pop),
    .full(in_full), .held(in_held), .is_end(in_is_end)
  );

  mbx_outbox u_out (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ld_head(ld_head), .ld_eng(ld_eng), .ld_tail(ld_tail),
    .eng_byte(tx_data), .take(take),
    .full(out_full), .frame(out_frame), .held(out_held)
  );

  mbx_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .ev_dwr(ev_dwr), .ev_cwr(ev_cwr), .ev_drd(ev_drd),
    .ev_cancel(ev_cancel), .ev_normal(ev_normal), .ev_end(ev_end),
    .in_full(in_full), .in_is_end(in_is_end), .rx_ready(rx_ready),
    .out_full(out_full), .out_frame(out_frame),
    .tx_valid(tx_valid), .tx_last(tx_last),
    .flush(flush), .ld_byte(ld_byte), .ld_end(ld_end), .pop(pop),
    .ld_head(ld_head), .ld_eng(ld_eng), .ld_tail(ld_tail), .take(take),
    .tx_ready(tx_ready), .status(status), .eng_abort(eng_abort)
  );

  assign rx_valid = in_full;
  assign rx_data  = in_held;
  assign rx_last  = in_is_end;

  // R1: nothing offered on either stream straight out of reset
  a_r1_quiet_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rx_valid && !tx_ready));

  // R10: the abort pulse lasts one cycle unless cancel repeats
  a_r10_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_abort && !(host_cs && host_wr && host_addr && host_wdata == 8'h22)) |=> !eng_abort);
endmodule

// File: tb/cmd_mailbox_test.sv
module cmd_mailbox_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_cs = 0, host_wr = 0, host_rd = 0, host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic       rx_valid, rx_last, tx_ready, eng_abort;
  logic       rx_ready = 0, tx_valid = 0, tx_last = 0;
  logic [7:0] rx_data, tx_data = 0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmd_mailbox uut (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_wr(host_wr),
    .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_last(rx_last), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .eng_abort(eng_abort)
  );

  // behavioural reference: phase 0 idle, 1 send, 2 reply, 3 tail
  int         m_ph;
  bit         m_ibf, m_end, m_obf, m_f0, m_a2, m_tail, m_abort;
  logic [7:0] m_ibuf, m_obuf;

  function automatic logic [7:0] m_status();
    return {2'b00, m_ph == 1, m_ph == 0, m_a2, m_f0, m_ibf, m_obf};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_ibf = 0; m_end = 0; m_obf = 0; m_f0 = 0;
      m_a2 = 0; m_tail = 0; m_abort = 0; m_ibuf = 0; m_obuf = 0;
    end else begin
      bit dw, cw, dr, rxpop, txacc, tk;
      dw = host_cs && host_wr && !host_addr;
      cw = host_cs && host_wr && host_addr;
      dr = host_cs && host_rd && !host_wr && !host_addr;
      rxpop = m_ibf && rx_ready;
      txacc = tx_valid && m_ph == 2 && !m_obf && !m_tail;
      tk = dr && m_obf;
      m_abort = cw && host_wdata == 8'h22;
      if (dw || cw) m_a2 = cw;
      if (m_abort) begin
        m_ph = 0; m_ibf = 0; m_end = 0; m_obf = 0; m_f0 = 0; m_tail = 0;
      end else begin
        if (m_ph == 0 && cw && host_wdata == 8'h01) m_ph = 1;
        else if (m_ph == 1 && !m_ibf && dw) begin
          m_ibf = 1; m_ibuf = host_wdata; m_end = 0;
        end else if (m_ph == 1 && !m_ibf && cw && host_wdata == 8'h03) begin
          m_ibf = 1; m_ibuf = 8'h03; m_end = 1;
        end else if (rxpop) begin
          if (m_end && m_ph == 1) begin
            m_obf = 1; m_f0 = 1; m_obuf = 8'h01; m_ph = 2;
          end
          m_ibf = 0; m_end = 0;
        end
        if (txacc) begin
          m_obf = 1; m_f0 = 0; m_obuf = tx_data;
          if (tx_last) m_tail = 1;
        end else if (tk) begin
          if (m_tail) begin
            m_obuf = 8'h03; m_f0 = 1; m_tail = 0; m_ph = 3;
          end else begin
            m_obf = 0; m_f0 = 0;
            if (m_ph == 3) m_ph = 0;
          end
        end
      end
    end
  end

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h at %0t", req, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R2 view of status/output)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 model rdata", host_rdata, host_addr ? m_status() : m_obuf);
      chk("R5 model rx_valid", {7'd0, rx_valid}, {7'd0, m_ibf});
      if (m_ibf) begin
        chk("R5 model rx_data", rx_data, m_ibuf);
        chk("R6 model rx_last", {7'd0, rx_last}, {7'd0, m_end});
      end
      chk("R8 model tx_ready", {7'd0, tx_ready},
          {7'd0, m_ph == 2 && !m_obf && !m_tail});
      chk("R10 model abort", {7'd0, eng_abort}, {7'd0, m_abort});
    end
  end

  task automatic hw(logic a, logic [7:0] d);
    @(negedge clk); #1;
    host_cs = 1; host_wr = 1; host_rd = 0; host_addr = a; host_wdata = d;
    @(negedge clk); #1;
    host_cs = 0; host_wr = 0;
  endtask

  task automatic hr(logic a, output logic [7:0] d);
    @(negedge clk); #1;
    host_cs = 1; host_rd = 1; host_wr = 0; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk); #1;
    host_cs = 0; host_rd = 0;
  endtask

  task automatic pop1();
    @(negedge clk); #1 rx_ready = 1;
    @(negedge clk); #1 rx_ready = 0;
  endtask

  task automatic give(logic [7:0] d, logic l);
    @(negedge clk); #1 tx_valid = 1; tx_data = d; tx_last = l;
    @(negedge clk); #1 tx_valid = 0; tx_last = 0;
  endtask

  task automatic st(output logic [7:0] s);
    host_addr = 1; #1 s = host_rdata;
  endtask

  task automatic od(output logic [7:0] s);
    host_addr = 0; #1 s = host_rdata;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, v;
    logic [7:0] resp [6] = '{8'h00, 8'hC4, 8'h00, 8'h00, 8'h00, 8'h06};
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    st(s); chk("R1 reset status", s, 8'h10);
    chk("R1 reset rx_valid", {7'd0, rx_valid}, 8'h00);
    chk("R1 reset tx_ready", {7'd0, tx_ready}, 8'h00);

    hw(0, 8'h55); st(s); chk("R5 data write in idle ignored / R3", s, 8'h10);
    hw(1, 8'h77); st(s); chk("R4 unknown code ignored / R3", s, 8'h18);
    hw(1, 8'h01); st(s); chk("R4 normal mode entered", s, 8'h28);

    hw(0, 8'hA1); st(s); chk("R5 byte loaded, R3 a2 clear", s, 8'h22);
    chk("R5 rx_data", rx_data, 8'hA1);
    hw(0, 8'hB2); chk("R5 write while full ignored", rx_data, 8'hA1);
    repeat (2) @(negedge clk);
    #1 chk("R5 beat held", rx_data, 8'hA1);
    pop1(); st(s); chk("R5 pop clears input full", s, 8'h20);
    hw(0, 8'hC3); chk("R5 second byte", rx_data, 8'hC3);
    pop1();

    hw(1, 8'h03); st(s); chk("R6 end beat loaded", s, 8'h2A);
    chk("R6 end beat data", rx_data, 8'h03);
    chk("R6 end beat last", {7'd0, rx_last}, 8'h01);
    pop1(); st(s); chk("R6 header framed", s, 8'h0D);
    od(v); chk("R6 header byte", v, 8'h01);
    chk("R8 no accept while full", {7'd0, tx_ready}, 8'h00);

    hr(1, v); st(s); chk("R7 status read no effect", s, 8'h0D);
    hr(0, v); chk("R7 header read value", v, 8'h01);
    st(s); chk("R7 data read clears", s, 8'h08);
    chk("R8 ready when empty", {7'd0, tx_ready}, 8'h01);

    for (int i = 0; i < 6; i++) begin
      give(resp[i], i == 5);
      st(s); chk("R8 engine byte pending", s, 8'h09);
      hr(0, v); chk("R8 byte through", v, resp[i]);
      st(s);
      if (i < 5) chk("R8 byte taken", s, 8'h08);
      else chk("R9 trailer framed", s, 8'h0D);
    end
    od(v); chk("R9 trailer byte", v, 8'h03);
    chk("R9 no accept with trailer", {7'd0, tx_ready}, 8'h00);
    hr(0, v); chk("R9 trailer read", v, 8'h03);
    st(s); chk("R9 back to ready", s, 8'h18);

    hw(1, 8'h01); hw(0, 8'h5A);
    chk("R10 beat before cancel", {7'd0, rx_valid}, 8'h01);
    hw(1, 8'h22); st(s); chk("R10 cancel mid-send", s, 8'h18);
    chk("R10 rx dropped", {7'd0, rx_valid}, 8'h00);
    chk("R10 abort high", {7'd0, eng_abort}, 8'h01);
    @(negedge clk); #1 chk("R10 abort one cycle", {7'd0, eng_abort}, 8'h00);

    hw(1, 8'h01); hw(1, 8'h22); st(s); chk("R10 back-to-back cancel", s, 8'h18);
    hw(1, 8'h01); st(s); chk("R4 normal after cancel", s, 8'h28);

    hw(0, 8'h11); pop1(); hw(1, 8'h03); pop1();
    st(s); chk("R6 second header", s, 8'h0D);
    hw(1, 8'h22); st(s); chk("R10 cancel in reply", s, 8'h18);
    chk("R10 tx_ready low", {7'd0, tx_ready}, 8'h00);
    repeat (2) @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule